// File: doc/BRIEF.md
# UART FIFO Control and Receive Trigger Logic

This block holds the write-only control register that sits beside a pair of 16-entry byte FIFOs in a UART. A CPU write to the register turns FIFO operation on or off, and can request a flush of either FIFO. It also picks the receive trigger level and selects the DMA signalling style. The FIFO storage itself lives elsewhere. This block only issues single-cycle flush pulses to it, reads back the receive occupancy and the per-entry error tags, and produces the flags that depend on them.

Bit 0 of a write is the master enable. All other bits are accepted only when bit 0 is 1 in the same write. Any write with bit 0 at 0 disables FIFO mode and flushes both FIFOs. Changing the mode in either direction also flushes both FIFOs.

The block also keeps the FIFO-mode error summary bit of the line status register. This bit follows the presence of parity, framing or break tags in the receive FIFO. It is held until the CPU reads the line status register, and that read re-evaluates it.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset, fifo_mode, dma_mode, trig_hit, rx_err_sum, rx_flush and tx_flush are all 0.
- R2: A write with wdata[0]=1 sets fifo_mode from the next cycle on. A write with wdata[0]=0 clears it from the next cycle on.
- R3: A write with wdata[0]=0, or a write with wdata[0]=1 while fifo_mode is 0, drives rx_flush and tx_flush both high for exactly the one cycle after the write.
- R4: A write with wdata[0]=1 while fifo_mode is 1 drives rx_flush high in the next cycle if and only if wdata[1]=1. It drives tx_flush high in the next cycle if and only if wdata[2]=1. Neither pulse lasts more than one cycle unless another write follows.
- R5: dma_mode equals the wdata[3] value of the last write with wdata[0]=1, and is forced to 0 while fifo_mode is 0. wdata[5:4] have no effect on any output.
- R6: wdata[7:6] of a write with wdata[0]=1 select the receive trigger level: 00 selects 1, 01 selects 4, 10 selects 8 and 11 selects 14 entries. A write with wdata[0]=0 leaves the selection unchanged.
- R7: trig_hit is 1 in the same cycle that fifo_mode is 1 and rx_count is greater than or equal to the selected level. Otherwise trig_hit is 0.
- R8: rx_err_sum is 0 while FIFO mode is off. In FIFO mode it becomes 1 in the cycle after any bit of rx_par_tag, rx_frm_tag or rx_brk_tag is 1.
- R9: Once set, rx_err_sum stays 1 after the tags clear, until a cycle with lsr_rd=1. That read clears it in the next cycle only if no tag bit is 1 in the read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| rx_count | input | CW (5) | Receive FIFO occupancy |
| rx_par_tag | input | DEPTH (16) | Parity error tag per valid receive entry |
| rx_frm_tag | input | DEPTH (16) | Framing error tag per valid receive entry |
| rx_brk_tag | input | DEPTH (16) | Break tag per valid receive entry |
| lsr_rd | input | 1 | Line status register read strobe |
| rx_flush | output | 1 | One-cycle flush request for the receive FIFO |
| tx_flush | output | 1 | One-cycle flush request for the transmit FIFO |
| fifo_mode | output | 1 | FIFO mode enabled |
| trig_hit | output | 1 | Receive occupancy has reached the trigger level |
| dma_mode | output | 1 | DMA signalling mode 1 selected |
| rx_err_sum | output | 1 | Error-in-FIFO summary bit for the line status register |

## Verification
A wrong stored trigger selection stays hidden until FIFO mode is on. It then shows at trig_hit in the same cycle that rx_count crosses a level boundary, so the bench sweeps rx_count across 0 to 16 for every level. A wrong mode or flush state shows one cycle after the offending write, as a missing or extra flush pulse or a wrong fifo_mode. A wrong sticky error state shows only after the tags clear, so the bench holds the tags low for several cycles before each lsr_rd. It also issues a read while tags are still present.

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl #(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [7:0]       ctl_wdata,
  input  logic [CW-1:0]    rx_count,
  input  logic [DEPTH-1:0] rx_par_tag,
  input  logic [DEPTH-1:0] rx_frm_tag,
  input  logic [DEPTH-1:0] rx_brk_tag,
  input  logic             lsr_rd,
  output logic             rx_flush,
  output logic             tx_flush,
  output logic             fifo_mode,
  output logic             trig_hit,
  output logic             dma_mode,
  output logic             rx_err_sum
);
  logic [1:0]    trig_sel;
  logic          dma_sel;
  logic [CW-1:0] level;
  logic          mode_nxt;
  logic          any_err;

  assign any_err  = |(rx_par_tag | rx_frm_tag | rx_brk_tag);
  assign mode_nxt = ctl_wr ? ctl_wdata[0] : fifo_mode;

  always_comb begin
    case (trig_sel)
      2'd0:    level = CW'(1);
      2'd1:    level = CW'(4);
      2'd2:    level = CW'(8);
      default: level = CW'(14);
    endcase
  end

  assign trig_hit = fifo_mode && (rx_count >= level);
  assign dma_mode = fifo_mode && dma_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_mode  <= 1'b0;
      trig_sel   <= 2'd0;
      dma_sel    <= 1'b0;
      rx_flush   <= 1'b0;
      tx_flush   <= 1'b0;
      rx_err_sum <= 1'b0;
    end else begin
      rx_flush <= 1'b0;
      tx_flush <= 1'b0;
      if (ctl_wr) begin
        fifo_mode <= ctl_wdata[0];
        if (!ctl_wdata[0] || !fifo_mode) begin
          rx_flush <= 1'b1;
          tx_flush <= 1'b1;
        end else begin
          rx_flush <= ctl_wdata[1];
          tx_flush <= ctl_wdata[2];
        end
        if (ctl_wdata[0]) begin
          trig_sel <= ctl_wdata[7:6];
          dma_sel  <= ctl_wdata[3];
        end
      end
      rx_err_sum <= mode_nxt && ((rx_err_sum && !lsr_rd) || any_err);
    end
  end
endmodule

module uart_fifo_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr,
  input logic [7:0] ctl_wdata,
  input logic       lsr_rd,
  input logic       rx_flush,
  input logic       tx_flush,
  input logic       fifo_mode,
  input logic       trig_hit,
  input logic       dma_mode,
  input logic       rx_err_sum
);
  a_r2_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_wdata[0] |=> fifo_mode);
  a_r3_off_flush: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !ctl_wdata[0] |=> rx_flush && tx_flush && !fifo_mode);
  a_r4_no_write_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> !rx_flush && !tx_flush);
  a_r5_dma_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    dma_mode |-> fifo_mode);
  a_r7_trig_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |-> fifo_mode);
  a_r8_off_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |-> !rx_err_sum);
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err_sum && !lsr_rd && !ctl_wr |=> rx_err_sum);
endmodule

bind uart_fifo_ctl uart_fifo_ctl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .lsr_rd(lsr_rd), .rx_flush(rx_flush), .tx_flush(tx_flush),
  .fifo_mode(fifo_mode), .trig_hit(trig_hit), .dma_mode(dma_mode),
  .rx_err_sum(rx_err_sum)
);

// File: tb/test_uart_fifo_ctl.sv
module test_uart_fifo_ctl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        ctl_wr = 0;
  logic [7:0]  ctl_wdata = 0;
  logic [4:0]  rx_count = 0;
  logic [15:0] rx_par_tag = 0, rx_frm_tag = 0, rx_brk_tag = 0;
  logic        lsr_rd = 0;
  logic        rx_flush, tx_flush, fifo_mode, trig_hit, dma_mode, rx_err_sum;

  int total = 0, bad = 0;
  int m_mode = 0, m_lvl = 1, m_dma = 0, m_rxf = 0, m_txf = 0, m_err = 0;

  always #5 clk = ~clk;

  uart_fifo_ctl i_uart_fifo_ctl (.*);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_lvl = 1; m_dma = 0; m_rxf = 0; m_txf = 0; m_err = 0;
    end else begin
      m_rxf = 0; m_txf = 0;
      if (ctl_wr) begin
        if (ctl_wdata[0] == 1'b0) begin
          m_rxf = 1; m_txf = 1; m_mode = 0;
        end else begin
          if (m_mode == 0) begin m_rxf = 1; m_txf = 1; end
          else begin m_rxf = ctl_wdata[1]; m_txf = ctl_wdata[2]; end
          m_mode = 1;
          m_dma = ctl_wdata[3];
          case (ctl_wdata[7:6])
            2'd0: m_lvl = 1;
            2'd1: m_lvl = 4;
            2'd2: m_lvl = 8;
            default: m_lvl = 14;
          endcase
        end
      end
      m_err = (m_mode != 0) &&
              (((m_err != 0) && !lsr_rd) ||
               ((rx_par_tag | rx_frm_tag | rx_brk_tag) != 0));
    end
  end

  task automatic chk(input string req, input string nm, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R2", "fifo_mode", int'(fifo_mode), m_mode);
    chk("R3/R4", "rx_flush", int'(rx_flush), m_rxf);
    chk("R3/R4", "tx_flush", int'(tx_flush), m_txf);
    chk("R5", "dma_mode", int'(dma_mode), (m_mode != 0 && m_dma != 0) ? 1 : 0);
    chk("R6/R7", "trig_hit", int'(trig_hit), (m_mode != 0 && int'(rx_count) >= m_lvl) ? 1 : 0);
    chk("R8/R9", "rx_err_sum", int'(rx_err_sum), m_err);
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk); ctl_wr = 1; ctl_wdata = d;
    @(negedge clk); ctl_wr = 0; ctl_wdata = 0;
  endtask

  task automatic sweep();
    for (int c = 0; c <= 16; c++) begin
      @(negedge clk); rx_count = 5'(c);
    end
    @(negedge clk); rx_count = 0;
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "reset outputs", {fifo_mode, dma_mode, trig_hit, rx_err_sum, rx_flush, tx_flush}, 0);
    rst_n = 1;
    // R8 tags ignored in non-FIFO mode; R7 trigger off
    @(negedge clk); rx_par_tag = 16'h0001; rx_count = 5'd16;
    repeat (3) @(negedge clk);
    rx_par_tag = 0; rx_count = 0;
    // R2 R3 enable, R6 each level with R7 sweep
    wr(8'h01); sweep();
    wr(8'h41); sweep();
    wr(8'h81); sweep();
    wr(8'hC9); sweep();
    // R4 selective flushes, R5 reserved bits 4/5 no effect
    wr(8'hC3); wr(8'hC5); wr(8'hF1); wr(8'hC7); wr(8'h39);
    // R6 write with bit0=0 keeps selection invisible while off
    wr(8'hC0); sweep(); wr(8'h00);
    wr(8'h41); sweep();
    // R8 R9 error summary
    @(negedge clk); rx_frm_tag = 16'h0100;
    repeat (2) @(negedge clk);
    lsr_rd = 1; @(negedge clk); lsr_rd = 0;
    repeat (2) @(negedge clk);
    rx_frm_tag = 0;
    repeat (4) @(negedge clk);
    lsr_rd = 1; @(negedge clk); lsr_rd = 0;
    repeat (3) @(negedge clk);
    rx_brk_tag = 16'h8000; @(negedge clk); rx_brk_tag = 0;
    repeat (3) @(negedge clk);
    wr(8'h47);
    repeat (2) @(negedge clk);
    lsr_rd = 1; rx_par_tag = 16'h0004; @(negedge clk); lsr_rd = 0; rx_par_tag = 0;
    repeat (2) @(negedge clk);
    // R8 disable clears summary
    rx_par_tag = 16'h0010; @(negedge clk);
    wr(8'h00);
    repeat (3) @(negedge clk);
    rx_par_tag = 0;
    // R2 back-to-back writes
    @(negedge clk); ctl_wr = 1; ctl_wdata = 8'h01;
    @(negedge clk); ctl_wdata = 8'h03;
    @(negedge clk); ctl_wdata = 8'h00;
    @(negedge clk); ctl_wr = 0;
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule